// File: doc/BRIEF.md
# Bus Isolation Stage Sequencer

This block raises and lowers the bus fences around one switchable power island. The fences are arranged as a fixed number of ordered stages. Each stage has its own configuration: a write mask that names the fence bits, a status mask that names the acknowledge bits, and four option flags. The flags swap the sense of the stage, take the acknowledge from a second status source, skip the acknowledge wait on a clear, and choose a merged write or a whole-register write. A one-cycle request starts a walk that covers every stage. To engage, the walk starts at the lowest stage and moves upward. To release, it starts at the highest stage and moves downward.

For each non-empty stage the block sends one write strobe. The strobe tells an external register port which register to hit (the set register or the clear register), the data, and a per-bit write enable. The block then samples the chosen status word at a fixed poll interval until the acknowledge condition is met. If the poll budget runs out first, the walk stops. The walk ends with a one-cycle `done` pulse, or with an `err` pulse that also records the index of the stage that failed. Each stage's configuration is read at the moment its turn comes up, so the configuration must be held stable while `busy` is high.

Top module: `bus_iso_sequencer`

## Requirements
- R1: An engage walk visits stages 0, 1, ..., N-1. A release walk visits stages N-1, ..., 0. Each non-empty stage visited produces exactly one `wr_en` cycle, with `wr_stage` set to its index. The first busy cycle never carries a write.
- R2: A stage whose write mask is zero is empty. An engage walk that reaches an empty stage ends there with `done`, and no higher stage is written. A release walk steps past an empty stage and goes on to the next lower stage.
- R3: A normal stage is engaged by a set operation and released by a clear operation. A stage with the invert flag swaps the two. `wr_to_set`=1 targets the set register and 0 targets the clear register.
- R4: A set operation is acknowledged only when every status-mask bit of the selected status word reads 1.
- R5: A clear operation is acknowledged when the masked status is all zero. When the stage's alternate-source flag is set, it is acknowledged when the masked status equals the full status mask instead. The status word comes from `sta_alt` when that flag is 1, and from `sta_main` otherwise.
- R6: A clear operation on a stage with the skip-acknowledge flag does not wait. The walk moves to the next stage in the cycle right after the write.
- R7: In merge mode (`cfg_merge`=1), `wr_ben` equals the write mask and `wr_data` equals the mask for a set or zero for a clear. In whole-register mode, `wr_ben` is all ones and `wr_data` equals the mask.
- R8: The status is first sampled POLL_CYCLES cycles after the write cycle, and again every POLL_CYCLES cycles after that. After MAX_POLLS failed samples the walk aborts. It pulses `err`, loads `err_stage` with the stage index, and writes no further stage. `err_stage` changes only together with `err`.
- R9: A request is taken only while idle. If both requests arrive in the same cycle, engage wins. Requests made while busy are ignored.
- R10: After reset, `busy`, `done`, `err` and `wr_en` are 0 and `err_stage` is 0. `busy` is 1 from the cycle after an accepted request until the cycle that carries `done` or `err`, and is 0 in that cycle. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_engage | input | 1 | Start an ascending engage walk |
| req_release | input | 1 | Start a descending release walk |
| cfg_wmask | input | N_STAGES*MASK_W | Per-stage write masks, stage i at bits [i*MASK_W +: MASK_W] |
| cfg_smask | input | N_STAGES*MASK_W | Per-stage status masks |
| cfg_invert | input | N_STAGES | Swap set and clear for the stage |
| cfg_alt_src | input | N_STAGES | Take the acknowledge from `sta_alt` (clear then expects all ones) |
| cfg_skip_clr_ack | input | N_STAGES | A clear needs no acknowledge |
| cfg_merge | input | N_STAGES | 1: merged write, 0: whole-register write |
| sta_main | input | N_STAGES*MASK_W | Primary status words |
| sta_alt | input | N_STAGES*MASK_W | Alternate status words |
| wr_en | output | 1 | Register write strobe |
| wr_stage | output | IDX_W | Stage being written |
| wr_to_set | output | 1 | 1: set register, 0: clear register |
| wr_data | output | MASK_W | Write data |
| wr_ben | output | MASK_W | Per-bit write enable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished without error (one cycle) |
| err | output | 1 | Walk aborted on acknowledge timeout (one cycle) |
| err_stage | output | IDX_W | Index of the last failing stage |

## Verification
Two pairs of events can land in the same cycle: the two walk requests, and a new request together with the `done` of the previous walk. The bench raises engage and release in one cycle, and expects an ascending walk made of set writes. It also pulses a request in the middle of a walk and expects the write order and the number of `done` pulses to stay the same. A behavioural reference thread follows every cycle. It accepts a request in the same cycle that reports `done`, so any cycle lost or double-counted at that boundary shows up as a mismatch in `busy`, `wr_en` or `done`.

// File: rtl/bus_iso_pkg.sv
package bus_iso_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_WRITE,
        SEQ_WAIT
    } seq_state_e;

    typedef struct packed {
        logic invert;
        logic alt_src;
        logic skip_clr_ack;
        logic merge;
    } stage_flags_t;

    // Engaging means set, unless the stage is inverted.
    function automatic logic op_is_set(input logic engage, input logic invert);
        return engage ^ invert;
    endfunction

    // True when the acknowledge expects every masked status bit high.
    function automatic logic expect_full(input logic is_set, input logic alt_src);
        return is_set | alt_src;
    endfunction

endpackage

// File: rtl/bus_iso_stage_pick.sv
module bus_iso_stage_pick
    import bus_iso_pkg::*;
#(
    parameter int unsigned N_STAGES = 4,
    parameter int unsigned MASK_W   = 8,
    parameter int unsigned IDX_W    = 2
) (
    input  logic [N_STAGES*MASK_W-1:0] cfg_wmask,
    input  logic [N_STAGES*MASK_W-1:0] cfg_smask,
    input  logic [N_STAGES-1:0]        cfg_invert,
    input  logic [N_STAGES-1:0]        cfg_alt_src,
    input  logic [N_STAGES-1:0]        cfg_skip_clr_ack,
    input  logic [N_STAGES-1:0]        cfg_merge,
    input  logic [N_STAGES*MASK_W-1:0] sta_main,
    input  logic [N_STAGES*MASK_W-1:0] sta_alt,
    input  logic [IDX_W-1:0]           sel_idx,
    input  logic                       sel_alt,
    output logic [MASK_W-1:0]          pick_wmask,
    output logic [MASK_W-1:0]          pick_smask,
    output stage_flags_t               pick_flags,
    output logic [MASK_W-1:0]          pick_sta
);

    logic [MASK_W-1:0] wm_arr  [N_STAGES];
    logic [MASK_W-1:0] sm_arr  [N_STAGES];
    logic [MASK_W-1:0] sta_arr [N_STAGES];
    stage_flags_t      fl_arr  [N_STAGES];

    for (genvar g = 0; g < N_STAGES; g++) begin : g_unpack
        assign wm_arr[g]  = cfg_wmask[g*MASK_W +: MASK_W];
        assign sm_arr[g]  = cfg_smask[g*MASK_W +: MASK_W];
        assign sta_arr[g] = sel_alt ? sta_alt[g*MASK_W +: MASK_W]
                                    : sta_main[g*MASK_W +: MASK_W];
        assign fl_arr[g]  = '{invert:       cfg_invert[g],
                              alt_src:      cfg_alt_src[g],
                              skip_clr_ack: cfg_skip_clr_ack[g],
                              merge:        cfg_merge[g]};
    end

    always_comb begin
        pick_wmask = '0;
        pick_smask = '0;
        pick_sta   = '0;
        pick_flags = '0;
        for (int i = 0; i < N_STAGES; i++) begin
            if (IDX_W'(i) == sel_idx) begin
                pick_wmask = wm_arr[i];
                pick_smask = sm_arr[i];
                pick_sta   = sta_arr[i];
                pick_flags = fl_arr[i];
            end
        end
    end

endmodule

// File: rtl/bus_iso_xfer.sv
module bus_iso_xfer
    import bus_iso_pkg::*;
#(
    parameter int unsigned MASK_W = 8
) (
    input  logic [MASK_W-1:0] wmask,
    input  logic [MASK_W-1:0] smask,
    input  logic [MASK_W-1:0] sta,
    input  logic              is_set,
    input  logic              alt_src,
    input  logic              merge,
    output logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] wr_ben,
    output logic              ack_ok
);

    logic [MASK_W-1:0] masked;
    logic              want_full;

    assign masked    = sta & smask;
    assign want_full = expect_full(is_set, alt_src);
    assign ack_ok    = want_full ? (masked == smask) : (masked == '0);

    // Merge: touch only the mask bits. Whole-register: the mask is the value.
    assign wr_ben  = merge ? wmask : '1;
    assign wr_data = (merge && !is_set) ? '0 : wmask;

endmodule

// File: rtl/bus_iso_ack_timer.sv
module bus_iso_ack_timer #(
    parameter int unsigned POLL_CYCLES = 2000,
    parameter int unsigned MAX_POLLS   = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic tick,
    output logic last
);

    localparam int unsigned CNT_W  = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int unsigned POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(POLL_CYCLES - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [POLL_W-1:0] polls_q;

    assign tick = run && (cnt_q == CNT_LAST);
    assign last = (polls_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt_q   <= '0;
            polls_q <= '0;
        end else if (run) begin
            if (tick) begin
                cnt_q <= '0;
                if (!last) polls_q <= polls_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    if (POLL_CYCLES > 1) begin : g_gap_chk
        // R8: samples are spaced by the poll interval
        assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
    end

endmodule

// File: rtl/bus_iso_sequencer.sv
module bus_iso_sequencer
    import bus_iso_pkg::*;
#(
    parameter int unsigned N_STAGES    = 4,
    parameter int unsigned MASK_W      = 8,
    parameter int unsigned POLL_CYCLES = 2000,
    parameter int unsigned MAX_POLLS   = 100000,
    localparam int unsigned IDX_W      = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_engage,
    input  logic                       req_release,
    input  logic [N_STAGES*MASK_W-1:0] cfg_wmask,
    input  logic [N_STAGES*MASK_W-1:0] cfg_smask,
    input  logic [N_STAGES-1:0]        cfg_invert,
    input  logic [N_STAGES-1:0]        cfg_alt_src,
    input  logic [N_STAGES-1:0]        cfg_skip_clr_ack,
    input  logic [N_STAGES-1:0]        cfg_merge,
    input  logic [N_STAGES*MASK_W-1:0] sta_main,
    input  logic [N_STAGES*MASK_W-1:0] sta_alt,
    output logic                       wr_en,
    output logic [IDX_W-1:0]           wr_stage,
    output logic                       wr_to_set,
    output logic [MASK_W-1:0]          wr_data,
    output logic [MASK_W-1:0]          wr_ben,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [IDX_W-1:0]           err_stage
);

    localparam logic [IDX_W-1:0] IDX_LOW  = '0;
    localparam logic [IDX_W-1:0] IDX_HIGH = IDX_W'(N_STAGES - 1);

    seq_state_e        state_q;
    logic              dir_eng_q;
    logic [IDX_W-1:0]  idx_q;
    logic [MASK_W-1:0] wmask_q;
    logic [MASK_W-1:0] smask_q;
    stage_flags_t      flags_q;
    logic              is_set_q;
    logic              done_q;
    logic              err_q;
    logic [IDX_W-1:0]  err_stage_q;

    logic [MASK_W-1:0] cur_wmask;
    logic [MASK_W-1:0] cur_smask;
    logic [MASK_W-1:0] cur_sta;
    stage_flags_t      cur_flags;
    logic              ack_ok;
    logic              poll_tick;
    logic              poll_last;
    logic              walk_end;
    logic [IDX_W-1:0]  idx_step;

    bus_iso_stage_pick #(
        .N_STAGES(N_STAGES),
        .MASK_W  (MASK_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .cfg_wmask       (cfg_wmask),
        .cfg_smask       (cfg_smask),
        .cfg_invert      (cfg_invert),
        .cfg_alt_src     (cfg_alt_src),
        .cfg_skip_clr_ack(cfg_skip_clr_ack),
        .cfg_merge       (cfg_merge),
        .sta_main        (sta_main),
        .sta_alt         (sta_alt),
        .sel_idx         (idx_q),
        .sel_alt         (flags_q.alt_src),
        .pick_wmask      (cur_wmask),
        .pick_smask      (cur_smask),
        .pick_flags      (cur_flags),
        .pick_sta        (cur_sta)
    );

    bus_iso_xfer #(
        .MASK_W(MASK_W)
    ) u_xfer (
        .wmask  (wmask_q),
        .smask  (smask_q),
        .sta    (cur_sta),
        .is_set (is_set_q),
        .alt_src(flags_q.alt_src),
        .merge  (flags_q.merge),
        .wr_data(wr_data),
        .wr_ben (wr_ben),
        .ack_ok (ack_ok)
    );

    bus_iso_ack_timer #(
        .POLL_CYCLES(POLL_CYCLES),
        .MAX_POLLS  (MAX_POLLS)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .arm (state_q == SEQ_WRITE),
        .run (state_q == SEQ_WAIT),
        .tick(poll_tick),
        .last(poll_last)
    );

    assign walk_end = dir_eng_q ? (idx_q == IDX_HIGH) : (idx_q == IDX_LOW);
    assign idx_step = dir_eng_q ? idx_q + 1'b1 : idx_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            dir_eng_q   <= 1'b0;
            idx_q       <= '0;
            wmask_q     <= '0;
            smask_q     <= '0;
            flags_q     <= '0;
            is_set_q    <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            err_stage_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (req_engage || req_release) begin
                        dir_eng_q <= req_engage;
                        idx_q     <= req_engage ? IDX_LOW : IDX_HIGH;
                        state_q   <= SEQ_LOAD;
                    end
                end
                SEQ_LOAD: begin
                    if (cur_wmask == '0) begin
                        if (dir_eng_q || idx_q == IDX_LOW) begin
                            done_q  <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end else begin
                        wmask_q  <= cur_wmask;
                        smask_q  <= cur_smask;
                        flags_q  <= cur_flags;
                        is_set_q <= op_is_set(dir_eng_q, cur_flags.invert);
                        state_q  <= SEQ_WRITE;
                    end
                end
                SEQ_WRITE: begin
                    if (!is_set_q && flags_q.skip_clr_ack) begin
                        if (walk_end) begin
                            done_q  <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            idx_q   <= idx_step;
                            state_q <= SEQ_LOAD;
                        end
                    end else begin
                        state_q <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (poll_tick) begin
                        if (ack_ok) begin
                            if (walk_end) begin
                                done_q  <= 1'b1;
                                state_q <= SEQ_IDLE;
                            end else begin
                                idx_q   <= idx_step;
                                state_q <= SEQ_LOAD;
                            end
                        end else if (poll_last) begin
                            err_q       <= 1'b1;
                            err_stage_q <= idx_q;
                            state_q     <= SEQ_IDLE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign wr_en     = (state_q == SEQ_WRITE);
    assign wr_stage  = idx_q;
    assign wr_to_set = is_set_q;
    assign busy      = (state_q != SEQ_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign err_stage = err_stage_q;

    // R10: a walk never ends both ways at once
    assert_end_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R10: busy only drops together with an end pulse
    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || err));

    // R1: every write is followed by a non-write cycle
    assert_single_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R1: the first busy cycle carries no write
    assert_load_first_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !wr_en);

    // R8: the failure index moves only with an error pulse
    assert_errstage_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_stage) |-> err);

endmodule

// File: tb/bus_iso_sequencer_tb.sv
`timescale 1ns/1ps
module bus_iso_sequencer_tb;

    localparam int NS = 4;
    localparam int W  = 8;
    localparam int PC = 3;
    localparam int MP = 5;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic req_e = 1'b0, req_r = 1'b0;
    logic [W-1:0] t_wm [NS], t_sm [NS], t_main [NS], t_alt [NS];
    logic t_inv [NS], t_altsel [NS], t_skip [NS], t_merge [NS], t_stall [NS];

    logic [NS*W-1:0] f_wm, f_sm, f_main, f_alt;
    logic [NS-1:0]   f_inv, f_altsel, f_skip, f_merge;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            f_wm[s*W +: W]   = t_wm[s];
            f_sm[s*W +: W]   = t_sm[s];
            f_main[s*W +: W] = t_main[s];
            f_alt[s*W +: W]  = t_alt[s];
            f_inv[s]    = t_inv[s];
            f_altsel[s] = t_altsel[s];
            f_skip[s]   = t_skip[s];
            f_merge[s]  = t_merge[s];
        end
    end

    logic          wr_en, wr_to_set, busy, done, err;
    logic [IW-1:0] wr_stage, err_stage;
    logic [W-1:0]  wr_data, wr_ben;

    bus_iso_sequencer #(
        .N_STAGES(NS), .MASK_W(W), .POLL_CYCLES(PC), .MAX_POLLS(MP)
    ) u_dut (
        .clk(clk), .rst(rst), .req_engage(req_e), .req_release(req_r),
        .cfg_wmask(f_wm), .cfg_smask(f_sm), .cfg_invert(f_inv),
        .cfg_alt_src(f_altsel), .cfg_skip_clr_ack(f_skip), .cfg_merge(f_merge),
        .sta_main(f_main), .sta_alt(f_alt),
        .wr_en(wr_en), .wr_stage(wr_stage), .wr_to_set(wr_to_set),
        .wr_data(wr_data), .wr_ben(wr_ben), .busy(busy), .done(done),
        .err(err), .err_stage(err_stage)
    );

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, one thread per walk ----------------
    logic e_busy = 0, e_done = 0, e_err = 0, e_wr = 0, e_toset = 0;
    int   e_stage = 0, e_errstg = 0;
    logic [W-1:0] e_data = '0, e_ben = '0;
    logic m_eng, m_set, m_ok, m_abort, m_stop;
    int   m_s;

    function automatic logic ref_ack(input int s, input logic set_op);
        logic [W-1:0] v;
        v = (t_altsel[s] ? t_alt[s] : t_main[s]) & t_sm[s];
        if (set_op || t_altsel[s]) return v == t_sm[s];
        return v == '0;
    endfunction

    always begin : ref_model
        @(posedge clk);
        e_done = 0; e_err = 0; e_wr = 0;
        if (rst) begin
            e_busy = 0; e_errstg = 0;
        end else if (req_e || req_r) begin
            m_eng = req_e; e_busy = 1; m_abort = 0; m_stop = 0; m_s = 0;
            for (int n = 0; n < NS && !m_stop; n++) begin
                m_s = m_eng ? n : NS - 1 - n;
                @(posedge clk);
                if (t_wm[m_s] == '0) begin
                    if (m_eng) m_stop = 1;
                    continue;
                end
                m_set   = m_eng ^ t_inv[m_s];
                e_wr    = 1; e_stage = m_s; e_toset = m_set;
                e_ben   = t_merge[m_s] ? t_wm[m_s] : '1;
                e_data  = (t_merge[m_s] && !m_set) ? '0 : t_wm[m_s];
                m_ok    = 0;
                @(posedge clk);
                e_wr = 0;
                if (!m_set && t_skip[m_s]) continue;
                for (int p = 0; p < MP && !m_ok; p++) begin
                    repeat (PC) @(posedge clk);
                    m_ok = ref_ack(m_s, m_set);
                end
                if (!m_ok) begin m_abort = 1; m_stop = 1; end
            end
            e_busy = 0;
            if (m_abort) begin e_err = 1; e_errstg = m_s; end
            else e_done = 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R10 busy", busy, e_busy);
            chk("R10 done", done, e_done);
            chk("R8 err", err, e_err);
            chk("R8 err_stage", err_stage, e_errstg);
            chk("R1 wr_en", wr_en, e_wr);
            if (e_wr) begin
                chk("R1 wr_stage", wr_stage, e_stage);
                chk("R3 wr_to_set", wr_to_set, e_toset);
                chk("R7 wr_data", wr_data, e_data);
                chk("R7 wr_ben", wr_ben, e_ben);
            end
        end
    end

    // ---------------- status responder and write log ----------------
    int   resp_dly = 1;
    int   pend [NS];
    logic pset [NS];
    int   wlog [$];
    logic lg_set [NS];
    logic [W-1:0] lg_data [NS], lg_ben [NS];
    bit   seen_done, seen_err;
    int   done_cnt = 0;

    always @(negedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (pend[s] > 0) begin
                pend[s]--;
                if (pend[s] == 0) begin
                    if (t_altsel[s]) t_alt[s] = t_alt[s] | t_sm[s];
                    else if (pset[s]) t_main[s] = t_main[s] | t_sm[s];
                    else t_main[s] = t_main[s] & ~t_sm[s];
                end
            end
        end
        if (wr_en) begin
            wlog.push_back(int'(wr_stage));
            lg_set[wr_stage]  = wr_to_set;
            lg_data[wr_stage] = wr_data;
            lg_ben[wr_stage]  = wr_ben;
            if (!t_stall[wr_stage]) begin
                pend[wr_stage] = resp_dly;
                pset[wr_stage] = wr_to_set;
            end
        end
        if (done) begin seen_done = 1; done_cnt++; end
        if (err) seen_err = 1;
    end

    function automatic int log_code();
        int c = 0;
        foreach (wlog[i]) c = c * 16 + wlog[i] + 1;
        return c;
    endfunction

    task automatic defaults();
        for (int s = 0; s < NS; s++) begin
            t_wm[s] = 8'h10 | (8'h01 << s);
            t_sm[s] = 8'h03 << (2 * s);
            t_inv[s] = 0; t_altsel[s] = 0; t_skip[s] = 0; t_merge[s] = 1; t_stall[s] = 0;
        end
    endtask

    task automatic walk(input logic e, input logic r);
        wlog.delete(); seen_done = 0; seen_err = 0;
        @(negedge clk); req_e = e; req_r = r;
        @(negedge clk); req_e = 0; req_r = 0;
        for (int g = 0; g < 400 && !(seen_done || seen_err); g++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        defaults();
        for (int s = 0; s < NS; s++) begin
            t_main[s] = '0; t_alt[s] = '0; pend[s] = 0; pset[s] = 0;
            lg_set[s] = 0; lg_data[s] = '0; lg_ben[s] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 0; cmp_on = 1;
        @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset wr_en", wr_en, 0);
        chk("R10 reset err_stage", err_stage, 0);

        // R1/R3: full engage then full release
        walk(1, 0);
        chk("R1 engage order", log_code(), 'h1234);
        chk("R10 engage done", seen_done, 1);
        chk("R3 engage uses set", lg_set[3], 1);
        chk("R4 set acknowledged", t_main[2] & t_sm[2], t_sm[2]);
        walk(0, 1);
        chk("R1 release order", log_code(), 'h4321);
        chk("R3 release uses clear", lg_set[2], 0);
        chk("R5 cleared status", t_main[1] & t_sm[1], 0);

        // R2: empty stage
        t_wm[2] = '0;
        walk(1, 0);
        chk("R2 engage stops at empty", log_code(), 'h12);
        walk(0, 1);
        chk("R2 release skips empty", log_code(), 'h421);
        chk("R2 release done", seen_done, 1);
        t_wm[2] = 8'h14;

        // R3/R5/R7: inverted, alternate source, whole-register write
        t_inv[1] = 1; t_altsel[2] = 1; t_merge[3] = 0;
        walk(1, 0);
        chk("R3 inverted engage clears", lg_set[1], 0);
        chk("R7 whole write data", lg_data[3], t_wm[3]);
        chk("R7 whole write enable", lg_ben[3], 8'hFF);
        chk("R7 merge set enable", lg_ben[0], t_wm[0]);
        walk(0, 1);
        chk("R3 inverted release sets", lg_set[1], 1);
        chk("R7 merge clear data", lg_data[0], 8'h00);
        chk("R5 alt release done", seen_done, 1);
        defaults();
        for (int s = 0; s < NS; s++) begin t_main[s] = '0; t_alt[s] = '0; end

        // R6: skip clear acknowledge with a silent responder
        walk(1, 0);
        t_stall[0] = 1; t_skip[0] = 1;
        walk(0, 1);
        chk("R6 skip ack done", seen_done, 1);
        chk("R6 skip ack no err", seen_err, 0);
        defaults();
        for (int s = 0; s < NS; s++) begin t_main[s] = '0; t_alt[s] = '0; end

        // R4/R8: partial acknowledge times out at stage 1
        t_stall[1] = 1; t_main[1] = t_sm[1] & 8'h04;
        walk(1, 0);
        chk("R4 partial ack errors", seen_err, 1);
        chk("R8 failing index", err_stage, 1);
        chk("R8 no later write", log_code(), 'h12);
        t_stall[1] = 0;
        walk(0, 1);
        chk("R8 err_stage holds", err_stage, 1);
        chk("R8 recovery done", seen_done, 1);

        // R9: simultaneous requests and requests while busy
        walk(1, 1);
        chk("R9 engage wins order", log_code(), 'h1234);
        chk("R9 engage wins op", lg_set[0], 1);
        wlog.delete(); seen_done = 0; done_cnt = 0;
        @(negedge clk); req_r = 1;
        @(negedge clk); req_r = 0;
        repeat (3) @(negedge clk); req_e = 1;
        @(negedge clk); req_e = 0;
        for (int g = 0; g < 400 && !seen_done; g++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R9 busy request ignored", log_code(), 'h4321);
        chk("R9 single done", done_cnt, 1);

        // R5: alternate source clear must ignore the primary word
        t_altsel[2] = 1; t_stall[2] = 1; t_alt[2] = t_sm[2]; t_main[2] = t_sm[2];
        walk(0, 1);
        chk("R5 alt clear expects full", seen_done, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule